// File: doc/BRIEF.md
# Three-Channel Square Tone Synthesizer

This block turns a single input clock into three independent square-wave tones and mixes them into one signed 16-bit sample per clock. A shared prescaler divides the clock by sixteen and emits a step tick. Each channel has a down-counter that moves on every tick. When that counter passes below zero, the channel's square output inverts and the counter reloads from the channel's 12-bit period. A separate 16-bit envelope divider runs from the same tick. It emits a one-clock wrap pulse each time it reloads from its own period.

The mixer adds up the 4-bit volumes of the channels whose square output is high and scales the sum by 512. The volumes are registered inside the block. The result is a new sample on every clock, marked by a valid strobe.

Top module: `tone_synth_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every square output, `sample_o`, `sample_valid_o` and `env_wrap_o` are 0, and all counters and registered volumes clear. This holds even when the volume inputs are nonzero.
- R2: The prescaler issues one step tick every 16 clocks. The first tick after reset release takes effect on the 16th rising edge, and the next ones on edges 32, 48 and so on.
- R3: On a tick, a channel counter at zero inverts that channel's square output and reloads from the period; otherwise it decrements. With period P, the square output inverts every 16*(P+1) clocks.
- R4: The channel counters start at zero after reset, so every square output goes to 1 on edge 16.
- R5: The period of channel k is `tone_period_i[12*k +: 12]`, all 12 bits significant. The value is read only at a reload, so a change never shortens or extends a countdown already under way.
- R6: A period of 0 inverts that channel on every tick (every 16 clocks).
- R7: The sample after edge n equals 512 times the sum of the volumes of the channels whose square output was 1 after edge n-1. Channel k's volume is `volume_i[4*k +: 4]`, registered one clock before use. The maximum value is 23040.
- R8: `sample_valid_o` is 1 on every clock from the first edge after reset release.
- R9: On a tick, the envelope counter reloads from `env_period_i` and pulses `env_wrap_o` for one clock if the counter is at 1 or 0; otherwise it decrements. With period P ≥ 1, the pulses fall on ticks 1, 1+P, 1+2P and so on.
- R10: An envelope period of 0 pulses `env_wrap_o` on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_period_i | input | 36 | Three 12-bit tone periods, channel k at bits 12k+11:12k |
| volume_i | input | 12 | Three 4-bit volumes, channel k at bits 4k+3:4k |
| env_period_i | input | 16 | Envelope divider period |
| square_o | output | 3 | Current square output of each channel |
| env_wrap_o | output | 1 | One-clock pulse on each envelope reload |
| sample_o | output | 16 | Signed mixed sample |
| sample_valid_o | output | 1 | Sample qualifier |

## Verification
The bench compares every clock against closed-form edge numbers. A design that counts the half-period as P ticks instead of P+1 would invert 16 clocks early. A design that starts its counters at the period instead of zero would delay the first edge. A period change made in mid-countdown is checked at the old and the new reload point, which catches a design that compares against the live input. A period of 256 catches a design that drops the high nibble. Zero periods on both the tone and envelope paths catch a design that stalls or wraps to 65535. Asserting reset with nonzero volumes catches a design that keeps stale volume in the mix.

// File: rtl/tsq_pkg.sv
// Shared constants for the tone synthesizer.
// Assumes three channels and a 16-bit signed output sample.
package tsq_pkg;
    localparam int TSQ_SAMPLE_W = 16;
    localparam int TSQ_MIX_SHIFT = 9;   // scale factor of 512
endpackage

// File: rtl/tsq_prescaler.sv
// Divides the clock by 2**LOG2_DIV and emits a one-cycle step tick.
// Assumes LOG2_DIV >= 1, so that no two ticks are adjacent.
module tsq_prescaler #(
    parameter int LOG2_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic [LOG2_DIV-1:0] cnt_q;

    // free-running divide counter
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = &cnt_q;

    // R2
    tick_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/tsq_tone_channel.sv
// One tone channel: a down-counter that inverts the square output when it passes zero.
// Assumes the period input is sampled only at a reload.
module tsq_tone_channel #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    output logic             square_o
);
    logic [PER_W-1:0] cnt_q;

    // count down on each tick; invert and reload when the counter passes zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            square_o <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == '0) begin
                cnt_q    <= period_i;
                square_o <= ~square_o;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R3
    sq_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(square_o));
endmodule

// File: rtl/tsq_env_divider.sv
// Envelope period divider: counts ticks and pulses once per reload.
// Assumes a period of 0 means a reload on every tick.
module tsq_env_divider #(
    parameter int ENV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [ENV_W-1:0] period_i,
    output logic             wrap_o
);
    logic [ENV_W-1:0] cnt_q;

    // decrement on a tick; reload and pulse when the count would reach zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_o <= 1'b0;
        end else begin
            wrap_o <= 1'b0;
            if (tick_i) begin
                if (cnt_q <= ENV_W'(1)) begin
                    cnt_q  <= period_i;
                    wrap_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R9
    env_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> $past(tick_i));
    // R9
    env_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);
endmodule

// File: rtl/tsq_mixer.sv
// Registers the volumes and adds those of the high channels, scaled by 512.
// Assumes the sum times 512 fits the signed sample width.
module tsq_mixer
    import tsq_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int VOL_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             square_i,
    input  logic [NUM_CH*VOL_W-1:0]       volume_i,
    output logic signed [TSQ_SAMPLE_W-1:0] sample_o,
    output logic                          valid_o
);
    localparam int SUM_W   = VOL_W + $clog2(NUM_CH + 1);
    localparam int MAX_SUM = NUM_CH * ((1 << VOL_W) - 1);

    logic [NUM_CH*VOL_W-1:0] vol_q;
    logic [SUM_W-1:0]        sum_c;

    // hold the volumes in registers so that a reset clears them
    always_ff @(posedge clk) begin
        if (!rst_n) vol_q <= '0;
        else        vol_q <= volume_i;
    end

    // add the volumes of the channels whose square output is high
    always_comb begin
        sum_c = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (square_i[k]) sum_c = sum_c + SUM_W'(vol_q[k*VOL_W +: VOL_W]);
        end
    end

    // register the scaled sample and its qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            sample_o <= $signed(TSQ_SAMPLE_W'(sum_c) << TSQ_MIX_SHIFT);
            valid_o  <= 1'b1;
        end
    end

    // R7
    sample_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sample_o[TSQ_MIX_SHIFT-1:0] == '0 &&
                     sample_o <= $signed(TSQ_SAMPLE_W'(MAX_SUM << TSQ_MIX_SHIFT))));
    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);
endmodule

// File: rtl/tone_synth_top.sv
// Three square tone channels and an envelope divider on one prescaler, mixed to one sample.
// Assumes a synchronous active-low reset and inputs that are stable at each clock edge.
module tone_synth_top
    import tsq_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int PER_W    = 12,
    parameter int VOL_W    = 4,
    parameter int ENV_W    = 16,
    parameter int LOG2_DIV = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH*PER_W-1:0]        tone_period_i,
    input  logic [NUM_CH*VOL_W-1:0]        volume_i,
    input  logic [ENV_W-1:0]               env_period_i,
    output logic [NUM_CH-1:0]              square_o,
    output logic                           env_wrap_o,
    output logic signed [TSQ_SAMPLE_W-1:0] sample_o,
    output logic                           sample_valid_o
);
    logic tick;

    tsq_prescaler #(.LOG2_DIV(LOG2_DIV)) presc_i (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        tsq_tone_channel #(.PER_W(PER_W)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .period_i (tone_period_i[k*PER_W +: PER_W]),
            .square_o (square_o[k])
        );
    end

    tsq_env_divider #(.ENV_W(ENV_W)) env_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .period_i(env_period_i), .wrap_o(env_wrap_o)
    );

    tsq_mixer #(.NUM_CH(NUM_CH), .VOL_W(VOL_W)) mix_i (
        .clk(clk), .rst_n(rst_n), .square_i(square_o), .volume_i(volume_i),
        .sample_o(sample_o), .valid_o(sample_valid_o)
    );
endmodule

// File: tb/tone_synth_top_tb_top.sv
module tone_synth_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] tone_period_i = '0;
    logic [11:0] volume_i = '0;
    logic [15:0] env_period_i = '0;
    logic [2:0]  square_o;
    logic        env_wrap_o;
    logic signed [15:0] sample_o;
    logic        sample_valid_o;

    int errors = 0;
    int checks = 0;
    int ecnt = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    // edges since reset release
    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    tone_synth_top dut_i (
        .clk(clk), .rst_n(rst_n), .tone_period_i(tone_period_i),
        .volume_i(volume_i), .env_period_i(env_period_i),
        .square_o(square_o), .env_wrap_o(env_wrap_o),
        .sample_o(sample_o), .sample_valid_o(sample_valid_o)
    );

    // rows: per0, per1, per2, vol0, vol1, vol2, env period
    localparam int NV = 5;
    localparam int VEC [NV][7] = '{
        '{0, 1, 2, 15, 15, 15, 3},
        '{3, 0, 5,  1,  2,  4, 0},
        '{2, 2, 2,  7,  0,  9, 1},
        '{1, 4, 0,  8,  8,  8, 5},
        '{5, 3, 1, 15,  0,  1, 2}
    };

    // square level after edge n for period p (R2, R3, R4)
    function automatic bit exp_sq(int p, int n);
        if (n < 16) return 1'b0;
        return (((n - 16) / (16 * (p + 1))) % 2) == 0;
    endfunction

    // envelope pulse after edge n for period p (R9, R10)
    function automatic bit exp_env(int p, int n);
        int t;
        if (n < 16 || (n % 16) != 0) return 1'b0;
        t = n / 16;
        if (p == 0) return 1'b1;
        return ((t - 1) % p) == 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at edge %0d", req, act, exp, ecnt);
        end
    endtask

    task automatic step_to(int n);
        while (ecnt < n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 square", square_o, 0);
        chk("R1 sample", sample_o, 0);
        chk("R1 valid", sample_valid_o, 0);
        chk("R1 env", env_wrap_o, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        // vector table walk
        for (int r = 0; r < NV; r++) begin
            tone_period_i = {12'(VEC[r][2]), 12'(VEC[r][1]), 12'(VEC[r][0])};
            volume_i      = {4'(VEC[r][5]), 4'(VEC[r][4]), 4'(VEC[r][3])};
            env_period_i  = 16'(VEC[r][6]);
            do_reset();
            for (int n = 1; n <= 232; n++) begin
                int es;
                logic [2:0] sq;
                step_to(n);
                for (int k = 0; k < 3; k++) sq[k] = exp_sq(VEC[r][k], n);
                es = 0;
                for (int k = 0; k < 3; k++)
                    if (exp_sq(VEC[r][k], n - 1)) es += VEC[r][3 + k];
                chk("R3/R4/R6 square", square_o, sq);
                chk("R7 sample", sample_o, es * 512);
                chk("R8 valid", sample_valid_o, 1);
                chk("R9/R10 env", env_wrap_o, exp_env(VEC[r][6], n));
            end
        end

        // R5: period change mid-countdown takes effect at next reload
        tone_period_i = {12'd0, 12'd0, 12'd10};
        volume_i = '0;
        env_period_i = 16'd0;
        do_reset();
        step_to(16);  chk("R4 first toggle", square_o[0], 1);
        step_to(20);  tone_period_i[11:0] = 12'd2;
        step_to(191); chk("R5 old period kept", square_o[0], 1);
        step_to(192); chk("R5 old period reload", square_o[0], 0);
        step_to(239); chk("R5 new period pending", square_o[0], 0);
        step_to(240); chk("R5 new period used", square_o[0], 1);

        // R5: high nibble of the period is significant (period 256)
        tone_period_i = {12'd0, 12'd0, 12'd256};
        do_reset();
        step_to(32);   chk("R5 no early toggle", square_o[0], 1);
        step_to(4127); chk("R5 wide period hold", square_o[0], 1);
        step_to(4128); chk("R5 wide period toggle", square_o[0], 0);

        // R1: reset in mid-run with full volumes clears everything
        tone_period_i = '0;
        volume_i = 12'hFFF;
        step_to(4200);
        do_reset();
        @(negedge clk);
        chk("R1 vol cleared sample", sample_o, 0);
        step_to(17);
        chk("R7 max sample", sample_o, 23040);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule